// File: doc/BRIEF.md
# UART Receive Holding and Line Status

This block sits between the receiver shift stage of a 16450-style UART and the host. Each byte the shift stage completes is offered for one cycle on `rx_valid`/`rx_byte`. When the single-byte holding register is free, the byte is stored there and the ready flag is set. When a byte arrives while the held byte is still unread, the new byte is dropped, the held byte stays intact, and an overrun flag is raised.

The host uses a small address/strobe port. Reads return the held byte or the line status byte. Writes load the interrupt-enable register and the modem-control register. The modem-control register drives the active-low handshake outputs and the interrupt output enable. It also selects internal loopback, where one of its bits stands in for the ring-indicate input. The line-status interrupt is a level that follows the overrun flag when enabled. It is driven off-chip only when the output-enable bit is set; a pad cell outside this block does the tri-stating.

Top module: `rx_hold_status`

## Requirements
- R1: After synchronous reset the status byte reads 0x00 (with both transmitter-empty inputs low), `dtr_n`, `rts_n` and `op2_n` are 1, and `irq_oe`, `irq_level` and `loop_en` are 0.
- R2: A byte offered with `rx_valid` while no unread byte is held is stored, and from the next cycle status bit 0 (ready) reads 1.
- R3: A read at address 0 returns the held byte during the access, and ready is 0 after that access unless a byte arrives in the same cycle.
- R4: A byte offered while ready is 1, with no address-0 read in that cycle, sets status bit 1 (overrun) and leaves the held byte unchanged.
- R5: If a byte arrives in the same cycle as an address-0 read, the read returns the old byte, the new byte is stored, ready stays 1, and no overrun is flagged.
- R6: A read at address 5 returns the status byte and clears overrun after the access, unless a new overrun arises in that same cycle.
- R7: `irq_level` is 1 while overrun is set and interrupt-enable bit 2 (written at address 1) is 1. It falls after the status read that clears overrun.
- R8: Modem-control bit 3 (written at address 4) gives `irq_oe` = 1 and `op2_n` = 0. When the bit is clear, `irq_oe` = 0 and `op2_n` = 1.
- R9: `dtr_n` is the inverse of modem-control bit 0, and `rts_n` is the inverse of modem-control bit 1.
- R10: Modem-control bit 4 sets `loop_en`. In loopback `ri_n_eff` is the inverse of modem-control bit 2; otherwise `ri_n_eff` follows `ri_n_in`.
- R11: Status bit 5 reflects `tx_hold_empty` and bit 6 reflects `tx_shift_empty`. Bits 2, 3, 4 and 7 read 0, and addresses other than 0 and 5 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Shift stage completed a byte this cycle |
| rx_byte | input | 8 | Completed byte |
| host_addr | input | 3 | Register address |
| host_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from address |
| tx_hold_empty | input | 1 | Transmit holding empty flag for status bit 5 |
| tx_shift_empty | input | 1 | Transmitter empty flag for status bit 6 |
| ri_n_in | input | 1 | Ring-indicate input pin, active low |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| op2_n | output | 1 | General purpose output, active low, mirrors interrupt enable |
| irq_level | output | 1 | Line-status interrupt level |
| irq_oe | output | 1 | Output enable for the interrupt pad |
| loop_en | output | 1 | Internal loopback selected |
| ri_n_eff | output | 1 | Ring-indicate value seen by modem status logic |

## Verification
A wrong ready or overrun flag shows on the next status read, one cycle after the byte or read that should have changed it. The interrupt level shows the same fault at once whenever the line interrupt is enabled. A wrong held byte shows only on the next address-0 read, so the bench reads the byte back after each overrun and after each simultaneous read-and-arrival. Stale modem-control state appears on the pins in the cycle after the write.

// File: rtl/rxh_pkg.sv
package rxh_pkg;

    localparam int BYTE_W     = 8;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        ADR_HOLD = 3'd0,
        ADR_IEN  = 3'd1,
        ADR_MCTL = 3'd4,
        ADR_STAT = 3'd5
    } reg_addr_e;

    localparam int IEN_LINE_BIT = 2;
    localparam int MC_DTR_BIT   = 0;
    localparam int MC_RTS_BIT   = 1;
    localparam int MC_RI_BIT    = 2;
    localparam int MC_OE_BIT    = 3;
    localparam int MC_LOOP_BIT  = 4;

    typedef struct packed {
        logic loop;
        logic irq_oe;
        logic ri_lb;
        logic rts;
        logic dtr;
    } mctl_t;

    typedef struct packed {
        logic       rsv7;
        logic       shift_empty;
        logic       hold_empty;
        logic [2:0] rsv;
        logic       overrun;
        logic       ready;
    } stat_t;

    typedef struct packed {
        logic rd_hold;
        logic rd_stat;
        logic wr_ien;
        logic wr_mctl;
    } host_op_t;

    function automatic host_op_t decode_op(logic rd, logic wr,
                                           logic [REG_ADDR_W-1:0] adr);
        host_op_t op;
        op.rd_hold = rd && (adr == ADR_HOLD);
        op.rd_stat = rd && (adr == ADR_STAT);
        op.wr_ien  = wr && (adr == ADR_IEN);
        op.wr_mctl = wr && (adr == ADR_MCTL);
        return op;
    endfunction

    function automatic mctl_t unpack_mctl(logic [BYTE_W-1:0] w);
        mctl_t m;
        m.dtr    = w[MC_DTR_BIT];
        m.rts    = w[MC_RTS_BIT];
        m.ri_lb  = w[MC_RI_BIT];
        m.irq_oe = w[MC_OE_BIT];
        m.loop   = w[MC_LOOP_BIT];
        return m;
    endfunction

    function automatic stat_t make_status(logic rdy, logic ovr,
                                          logic he, logic se);
        stat_t s;
        s             = '0;
        s.ready       = rdy;
        s.overrun     = ovr;
        s.hold_empty  = he;
        s.shift_empty = se;
        return s;
    endfunction

endpackage

// File: rtl/rxh_capture.sv
module rxh_capture
    import rxh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rd_hold,
    input  logic              rd_stat,
    output logic [BYTE_W-1:0] hold_q,
    output logic              ready_q,
    output logic              ovr_q
);
    logic take;
    logic clash;

    // A byte is accepted when the holder is free or being emptied now.
    assign take  = rx_valid && (!ready_q || rd_hold);
    assign clash = rx_valid && ready_q && !rd_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (take) begin
                hold_q <= rx_byte;
            end
            ready_q <= take || (ready_q && !rd_hold);
            ovr_q   <= clash || (ovr_q && !rd_stat);
        end
    end
endmodule

// File: rtl/rxh_ctrl_regs.sv
module rxh_ctrl_regs
    import rxh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ien,
    input  logic              wr_mctl,
    input  logic [BYTE_W-1:0] wdata,
    output logic              ien_line,
    output mctl_t             mctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ien_line <= 1'b0;
            mctl     <= '0;
        end else begin
            if (wr_ien) begin
                ien_line <= wdata[IEN_LINE_BIT];
            end
            if (wr_mctl) begin
                mctl <= unpack_mctl(wdata);
            end
        end
    end
endmodule

// File: rtl/rxh_pins.sv
module rxh_pins
    import rxh_pkg::*;
(
    input  mctl_t mctl,
    input  logic  ien_line,
    input  logic  ovr_q,
    input  logic  ri_n_in,
    output logic  dtr_n,
    output logic  rts_n,
    output logic  op2_n,
    output logic  irq_level,
    output logic  irq_oe,
    output logic  loop_en,
    output logic  ri_n_eff
);
    always_comb begin
        dtr_n     = !mctl.dtr;
        rts_n     = !mctl.rts;
        op2_n     = !mctl.irq_oe;
        irq_oe    = mctl.irq_oe;
        irq_level = ovr_q && ien_line;
        loop_en   = mctl.loop;
        ri_n_eff  = mctl.loop ? !mctl.ri_lb : ri_n_in;
    end
endmodule

// File: rtl/rx_hold_status.sv
module rx_hold_status
    import rxh_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_valid,
    input  logic [BYTE_W-1:0]     rx_byte,
    input  logic [REG_ADDR_W-1:0] host_addr,
    input  logic                  host_rd,
    input  logic                  host_wr,
    input  logic [BYTE_W-1:0]     host_wdata,
    output logic [BYTE_W-1:0]     host_rdata,
    input  logic                  tx_hold_empty,
    input  logic                  tx_shift_empty,
    input  logic                  ri_n_in,
    output logic                  dtr_n,
    output logic                  rts_n,
    output logic                  op2_n,
    output logic                  irq_level,
    output logic                  irq_oe,
    output logic                  loop_en,
    output logic                  ri_n_eff
);
    host_op_t          op;
    logic [BYTE_W-1:0] hold_q;
    logic              ready_q;
    logic              ovr_q;
    logic              ien_line;
    mctl_t             mctl;
    stat_t             stat;

    assign op = decode_op(host_rd, host_wr, host_addr);

    rxh_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rd_hold  (op.rd_hold),
        .rd_stat  (op.rd_stat),
        .hold_q   (hold_q),
        .ready_q  (ready_q),
        .ovr_q    (ovr_q)
    );

    rxh_ctrl_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_ien   (op.wr_ien),
        .wr_mctl  (op.wr_mctl),
        .wdata    (host_wdata),
        .ien_line (ien_line),
        .mctl     (mctl)
    );

    rxh_pins u_pins (
        .mctl      (mctl),
        .ien_line  (ien_line),
        .ovr_q     (ovr_q),
        .ri_n_in   (ri_n_in),
        .dtr_n     (dtr_n),
        .rts_n     (rts_n),
        .op2_n     (op2_n),
        .irq_level (irq_level),
        .irq_oe    (irq_oe),
        .loop_en   (loop_en),
        .ri_n_eff  (ri_n_eff)
    );

    assign stat = make_status(ready_q, ovr_q, tx_hold_empty, tx_shift_empty);

    always_comb begin
        case (host_addr)
            ADR_HOLD: host_rdata = hold_q;
            ADR_STAT: host_rdata = stat;
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rxh_checker.sv
module rxh_checker
    import rxh_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              rd_hold,
    input logic              rd_stat,
    input logic              wr_ien,
    input logic              wr_mctl,
    input logic [BYTE_W-1:0] wdata,
    input logic [BYTE_W-1:0] hold_q,
    input logic              ready_q,
    input logic              ovr_q,
    input logic              irq_level,
    input logic              irq_oe,
    input logic              op2_n,
    input logic              dtr_n,
    input logic              rts_n
);
    a_r2_store: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !ready_q) |=> ready_q);

    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_hold && !rx_valid) |=> !ready_q);

    a_r4_keep_held: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && ready_q && !rd_hold) |=> (ovr_q && hold_q == $past(hold_q)));

    a_r5_swap_no_ovr: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rd_hold && !ovr_q) |=> (ready_q && !ovr_q));

    a_r6_stat_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !(rx_valid && ready_q && !rd_hold)) |=> !ovr_q);

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_level && !rd_stat && !wr_ien) |=> irq_level);

    a_r8_oe_pins: assert property (@(posedge clk) disable iff (rst)
        wr_mctl |=> (irq_oe == $past(wdata[MC_OE_BIT])) && (op2_n != irq_oe));

    a_r9_handshake: assert property (@(posedge clk) disable iff (rst)
        wr_mctl |=> (dtr_n == !$past(wdata[MC_DTR_BIT])) &&
                    (rts_n == !$past(wdata[MC_RTS_BIT])));
endmodule

bind rx_hold_status rxh_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rd_hold   (op.rd_hold),
    .rd_stat   (op.rd_stat),
    .wr_ien    (op.wr_ien),
    .wr_mctl   (op.wr_mctl),
    .wdata     (host_wdata),
    .hold_q    (hold_q),
    .ready_q   (ready_q),
    .ovr_q     (ovr_q),
    .irq_level (irq_level),
    .irq_oe    (irq_oe),
    .op2_n     (op2_n),
    .dtr_n     (dtr_n),
    .rts_n     (rts_n)
);

// File: tb/tb_rx_hold_status.sv
`timescale 1ns/1ps
module tb_rx_hold_status;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [2:0] host_addr = '0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       tx_hold_empty = 1'b0;
    logic       tx_shift_empty = 1'b0;
    logic       ri_n_in = 1'b1;
    logic       dtr_n, rts_n, op2_n, irq_level, irq_oe, loop_en, ri_n_eff;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = !clk;

    rx_hold_status dut (.*);

    typedef struct packed {
        logic       is_rx;
        logic [2:0] adr;
        logic [7:0] dat;
        logic [7:0] expv;
        logic [3:0] req;
    } vec_t;

    // Table: receive entries push a byte, read entries compare read data.
    localparam vec_t [0:10] TBL = '{
        '{1'b0, 3'd5, 8'h00, 8'h00, 4'd1},  // R1 reset status
        '{1'b1, 3'd0, 8'hA5, 8'h00, 4'd2},
        '{1'b0, 3'd5, 8'h00, 8'h01, 4'd2},  // R2 ready set
        '{1'b0, 3'd0, 8'h00, 8'hA5, 4'd3},  // R3 byte returned
        '{1'b0, 3'd5, 8'h00, 8'h00, 4'd3},  // R3 ready cleared
        '{1'b1, 3'd0, 8'h3C, 8'h00, 4'd4},
        '{1'b1, 3'd0, 8'h77, 8'h00, 4'd4},
        '{1'b0, 3'd5, 8'h00, 8'h03, 4'd4},  // R4 overrun flagged
        '{1'b0, 3'd5, 8'h00, 8'h01, 4'd6},  // R6 overrun cleared
        '{1'b0, 3'd0, 8'h00, 8'h3C, 4'd4},  // R4 held byte kept
        '{1'b0, 3'd1, 8'h00, 8'h00, 4'd11}  // R11 unmapped address
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp_v,
                       input string tag);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(posedge clk);
        #1 rx_valid = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp_v,
                          input string tag);
        @(negedge clk);
        host_addr = a;
        host_rd   = 1'b1;
        #1 chk(host_rdata, exp_v, tag);
        @(posedge clk);
        #1 host_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(posedge clk);
        #1 host_wr = 1'b0;
    endtask

    task automatic pins_chk(input logic [3:0] exp_v, input string tag);
        @(negedge clk);
        chk({4'h0, dtr_n, rts_n, op2_n, irq_oe}, {4'h0, exp_v}, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        pins_chk(4'b1110, "R1 dtr_n/rts_n/op2_n/irq_oe after reset");
        @(negedge clk);
        chk({6'h0, irq_level, loop_en}, 8'h00, "R1 irq_level/loop_en after reset");

        foreach (TBL[i]) begin
            if (TBL[i].is_rx) begin
                rx_push(TBL[i].dat);
            end else begin
                rd_chk(TBL[i].adr, TBL[i].expv,
                       $sformatf("R%0d table entry %0d", TBL[i].req, i));
            end
        end

        // R5: arrival in the same cycle as a holding read
        rx_push(8'h11);
        @(negedge clk);
        host_addr = 3'd0;
        host_rd   = 1'b1;
        rx_valid  = 1'b1;
        rx_byte   = 8'h22;
        #1 chk(host_rdata, 8'h11, "R5 old byte returned");
        @(posedge clk);
        #1 begin host_rd = 1'b0; rx_valid = 1'b0; end
        rd_chk(3'd5, 8'h01, "R5 ready kept, no overrun");
        rd_chk(3'd0, 8'h22, "R5 new byte stored");

        // R6: new overrun coincides with a status read
        rx_push(8'h44);
        @(negedge clk);
        host_addr = 3'd5;
        host_rd   = 1'b1;
        rx_valid  = 1'b1;
        rx_byte   = 8'h55;
        #1 chk(host_rdata, 8'h01, "R6 status before collision");
        @(posedge clk);
        #1 begin host_rd = 1'b0; rx_valid = 1'b0; end

        // R7: interrupt follows overrun only when enabled
        @(negedge clk);
        chk({7'h0, irq_level}, 8'h00, "R7 irq masked while disabled");
        wr_reg(3'd1, 8'h04);
        @(negedge clk);
        chk({7'h0, irq_level}, 8'h01, "R7 irq raised by overrun");
        rd_chk(3'd5, 8'h03, "R6 overrun survived collision");
        @(negedge clk);
        chk({7'h0, irq_level}, 8'h00, "R7 irq dropped after status read");
        rd_chk(3'd0, 8'h44, "R4 held byte kept across collision");

        // R8 and R9: modem-control outputs
        wr_reg(3'd4, 8'h08);
        pins_chk(4'b1101, "R8 output enable set");
        wr_reg(3'd4, 8'h01);
        pins_chk(4'b0110, "R9 dtr asserted");
        wr_reg(3'd4, 8'h02);
        pins_chk(4'b1010, "R9 rts asserted");

        // R10: loopback ring indicate
        wr_reg(3'd4, 8'h10);
        @(negedge clk);
        chk({6'h0, loop_en, ri_n_eff}, 8'h03, "R10 loopback, ri bit 0");
        wr_reg(3'd4, 8'h14);
        @(negedge clk);
        chk({6'h0, loop_en, ri_n_eff}, 8'h02, "R10 loopback, ri bit 1");
        wr_reg(3'd4, 8'h04);
        ri_n_in = 1'b0;
        @(negedge clk);
        chk({6'h0, loop_en, ri_n_eff}, 8'h00, "R10 normal, pin low");
        ri_n_in = 1'b1;
        @(negedge clk);
        chk({6'h0, loop_en, ri_n_eff}, 8'h01, "R10 normal, pin high");

        // R11: transmitter flags in status
        tx_hold_empty = 1'b1;
        rd_chk(3'd5, 8'h20, "R11 hold-empty bit 5");
        tx_shift_empty = 1'b1;
        rd_chk(3'd5, 8'h60, "R11 both empty bits");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule